// File: doc/BRIEF.md
# PC Sample Histogram Bucket Generator

This block sits beside a profiling monitor. At every monitor tick it receives a sampled program counter and a flag telling whether the sample was taken in kernel or user mode. If the sample lies inside the configured address window and was taken in the selected mode, the block works out which histogram bucket the address belongs to. It then raises a one-cycle increment request, made up of a strobe and a bucket index, toward an external histogram memory. Allocating that memory and reading it back are handled elsewhere.

Buckets group a power-of-two number of consecutive 4-byte instructions, set by the stride. A stride of zero folds the whole window into bucket 0. A configuration write loads the window, the stride and the mode in one cycle. A write whose stride is not zero and not a power of two is refused as a whole.

Top module: `hist_bucket_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hist_inc` is low. Reset loads window base 0, window limit `DEF_LIMIT`, a stride of 4 instructions and user mode.
- R2: A tick whose sample is in the window and in the selected mode raises `hist_inc` for exactly one cycle, on the clock edge after the tick, with `hist_idx` valid in that same cycle.
- R3: For a nonzero stride S, `hist_idx` is the low `IDX_W` bits of (pc - base) / (4*S), which equals (pc - base) shifted right by 2 + log2(S).
- R4: A stride of 0 makes `hist_idx` 0 for every accepted sample.
- R5: The window includes the base and excludes the limit. A sample with pc below base, or with pc equal to or above the limit, raises no strobe. All comparisons are unsigned.
- R6: `cfg_kernel` = 1 selects kernel samples (`pc_kernel` = 1), and `cfg_kernel` = 0 selects user samples (`pc_kernel` = 0). A sample in the other mode raises no strobe.
- R7: A configuration write whose `cfg_stride` has two or more bits set is ignored, and base, limit, stride and mode all keep their previous values. Any other write replaces all four on the next edge.
- R8: With the stride left at its reset value of 4, each bucket covers 16 bytes. The window therefore holds one quarter as many buckets as it holds instructions.
- R9: With no tick there is no strobe. A tick that shares a cycle with a configuration write is judged against the configuration in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_base | input | ADDR_W | Window base byte address, inclusive |
| cfg_limit | input | ADDR_W | Window limit byte address, exclusive |
| cfg_stride | input | STRIDE_W | Instructions per bucket: 0 or a power of two |
| cfg_kernel | input | 1 | Mode select: 1 for kernel, 0 for user |
| tick | input | 1 | Monitor tick; the sample is valid in this cycle |
| pc | input | ADDR_W | Sampled program counter, byte address |
| pc_kernel | input | 1 | Sample privilege: 1 for kernel, 0 for user |
| hist_inc | output | 1 | Histogram increment strobe |
| hist_idx | output | IDX_W | Bucket index for the increment |

## Verification
The bench builds the block with a 16-bit address, an 8-bit index, an 8-bit stride field and a 0x400 default limit. These small sizes let a short run reach the largest stride of 128 instructions, which shifts by 9. They also let wide windows with a stride of 1 produce offsets whose quotient no longer fits in the index, so truncation to the low bits is exercised. Window edges at base-1, base, limit-1 and limit are all easy to hit, and ticks that share a cycle with a write, including a refused write, show which configuration applies to them.

// File: rtl/hist_bucket_gen.sv
module hist_bucket_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 16,
  parameter int STRIDE_W = 8,
  parameter logic [ADDR_W-1:0] DEF_LIMIT = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic              cfg_kernel,
  input  logic              tick,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pc_kernel,
  output logic              hist_inc,
  output logic [IDX_W-1:0]  hist_idx
);
  localparam int EXP_W = (STRIDE_W > 1) ? $clog2(STRIDE_W) : 1;
  localparam int SH_W = EXP_W + 1;

  logic [ADDR_W-1:0] base_q, limit_q;
  logic [EXP_W-1:0]  exp_q;
  logic              zero_q, kern_q;

  logic [EXP_W-1:0]  wr_exp;
  logic              wr_ok;
  logic [ADDR_W-1:0] offset;
  logic [SH_W-1:0]   sh;
  logic              hit;

  assign wr_ok = (cfg_stride & (cfg_stride - STRIDE_W'(1))) == '0;

  always_comb begin
    wr_exp = '0;
    for (int i = 0; i < STRIDE_W; i++)
      if (cfg_stride[i]) wr_exp = EXP_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= DEF_LIMIT;
      exp_q   <= EXP_W'(2);
      zero_q  <= 1'b0;
      kern_q  <= 1'b0;
    end else if (cfg_wr && wr_ok) begin
      base_q  <= cfg_base;
      limit_q <= cfg_limit;
      exp_q   <= wr_exp;
      zero_q  <= cfg_stride == '0;
      kern_q  <= cfg_kernel;
    end
  end

  assign offset = pc - base_q;
  assign sh     = SH_W'(exp_q) + SH_W'(2);
  assign hit    = tick && (pc >= base_q) && (pc < limit_q) && (pc_kernel == kern_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_inc <= 1'b0;
      hist_idx <= '0;
    end else begin
      hist_inc <= hit;
      if (hit) hist_idx <= zero_q ? '0 : IDX_W'(offset >> sh);
    end
  end
endmodule

module hist_bucket_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 16,
  parameter int STRIDE_W = 8,
  parameter int EXP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [STRIDE_W-1:0] cfg_stride,
  input logic              tick,
  input logic [ADDR_W-1:0] pc,
  input logic              pc_kernel,
  input logic              hist_inc,
  input logic [IDX_W-1:0]  hist_idx,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic [EXP_W-1:0]  exp_q,
  input logic              zero_q,
  input logic              kern_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !hist_inc);
  p_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hist_inc |-> $past(tick));
  p_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hist_inc |-> ($past(pc) >= $past(base_q)) && ($past(pc) < $past(limit_q)));
  p_mode_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hist_inc |-> $past(pc_kernel) == $past(kern_q));
  p_zero_bucket_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hist_inc && $past(zero_q) |-> hist_idx == '0);
  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && ($countones(cfg_stride) > 1) |=>
      $stable(base_q) && $stable(limit_q) && $stable(exp_q) && $stable(zero_q) && $stable(kern_q));
endmodule

bind hist_bucket_gen hist_bucket_gen_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W), .EXP_W(EXP_W)
) u_chk (.*);

// File: tb/test_hist_bucket_gen.sv
module test_hist_bucket_gen;
  localparam int AW = 16;
  localparam int IW = 8;
  localparam int SW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_kernel = 0, tick = 0, pc_kernel = 0;
  logic [AW-1:0] cfg_base = 0, cfg_limit = 0, pc = 0;
  logic [SW-1:0] cfg_stride = 0;
  logic hist_inc;
  logic [IW-1:0] hist_idx;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit started = 0;

  int unsigned m_base, m_limit, m_stride;
  bit m_kern, exp_inc;
  int unsigned exp_idx;

  always #10 clk = ~clk;

  hist_bucket_gen #(.ADDR_W(AW), .IDX_W(IW), .STRIDE_W(SW), .DEF_LIMIT(16'h0400)) i_hist_bucket_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_stride(cfg_stride), .cfg_kernel(cfg_kernel), .tick(tick), .pc(pc),
    .pc_kernel(pc_kernel), .hist_inc(hist_inc), .hist_idx(hist_idx));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_limit = 'h400; m_stride = 4; m_kern = 0;
      exp_inc = 0; exp_idx = 0;
    end else begin
      exp_inc = tick && (int'(pc) >= m_base) && (int'(pc) < m_limit) && (pc_kernel == m_kern);
      if (exp_inc)
        exp_idx = (m_stride == 0) ? 0 : ((int'(pc) - m_base) / (4 * m_stride)) % 256;
      if (cfg_wr && $countones(cfg_stride) <= 1) begin
        m_base = cfg_base; m_limit = cfg_limit; m_stride = cfg_stride; m_kern = cfg_kernel;
      end
    end
  end

  always @(negedge clk) if (started) begin
    checks++;
    if (hist_inc !== exp_inc) begin
      fails++;
      $display("FAIL %s: hist_inc actual %0b expected %0b (t=%0t)", cur_req, hist_inc, exp_inc, $time);
    end else if (exp_inc) begin
      checks++;
      if (int'(hist_idx) != exp_idx) begin
        fails++;
        $display("FAIL %s: hist_idx actual %0d expected %0d (t=%0t)", cur_req, hist_idx, exp_idx, $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 0; cfg_wr = 0;
    end
  endtask

  task automatic samp(logic [AW-1:0] a, logic k);
    @(negedge clk); cfg_wr = 0; tick = 1; pc = a; pc_kernel = k;
  endtask

  task automatic cfg(logic [AW-1:0] b, logic [AW-1:0] l, logic [SW-1:0] s, logic k);
    @(negedge clk); tick = 0; cfg_wr = 1; cfg_base = b; cfg_limit = l; cfg_stride = s; cfg_kernel = k;
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    started = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);

    cur_req = "R8";
    for (int a = 0; a < 'h440; a += 12) samp(AW'(a), 0);
    samp(16'h0040, 1);
    samp(16'h03FC, 0);
    idle(2);

    cur_req = "R3";
    cfg(16'h1000, 16'h2000, 8, 0);
    for (int a = 'h0FF0; a < 'h2010; a += 36) samp(AW'(a), 0);
    cfg(16'h0100, 16'h8000, 1, 0);
    for (int a = 'h0100; a < 'h8000; a += 'h1F3) samp(AW'(a), 0);
    cfg(16'h0000, 16'hFFFF, 128, 0);
    for (int a = 0; a < 'hFFFF; a += 'h301) samp(AW'(a), 0);
    cfg(16'h0002, 16'h0400, 2, 0);
    for (int a = 0; a < 'h40; a += 3) samp(AW'(a), 0);

    cur_req = "R4";
    cfg(16'h3000, 16'h3800, 0, 0);
    for (int a = 'h2FF8; a < 'h3808; a += 'h55) samp(AW'(a), 0);

    cur_req = "R5";
    cfg(16'h4000, 16'h4100, 4, 1);
    samp(16'h3FFF, 1); samp(16'h4000, 1); samp(16'h40FF, 1);
    samp(16'h4100, 1); samp(16'h0000, 1); samp(16'hFFFF, 1);
    cfg(16'h5000, 16'h5000, 4, 1);
    samp(16'h5000, 1); samp(16'h4FFF, 1);

    cur_req = "R6";
    cfg(16'h0000, 16'h2000, 4, 1);
    for (int i = 0; i < 20; i++) samp(AW'(i * 'h77), i[0]);
    cfg(16'h0000, 16'h2000, 4, 0);
    for (int i = 0; i < 20; i++) samp(AW'(i * 'h77), i[1]);

    cur_req = "R7";
    cfg(16'h0800, 16'h0C00, 16, 0);
    cfg(16'h0000, 16'hF000, 3, 1);
    samp(16'h0900, 0); samp(16'h0900, 1); samp(16'h0400, 0);
    cfg(16'h0000, 16'hF000, 8'h81, 1);
    cfg(16'h0000, 16'hF000, 6, 1);
    samp(16'h0BFC, 0); samp(16'h0C00, 0);

    cur_req = "R9";
    idle(4);
    @(negedge clk); tick = 1; pc = 16'h0A00; pc_kernel = 0;
    cfg_wr = 1; cfg_base = 16'h2000; cfg_limit = 16'h3000; cfg_stride = 1; cfg_kernel = 1;
    @(negedge clk); cfg_wr = 0; tick = 1; pc = 16'h2010; pc_kernel = 1;
    @(negedge clk); tick = 1; pc = 16'h0A00; pc_kernel = 0;
    cfg_wr = 1; cfg_base = 16'h0000; cfg_limit = 16'h0100; cfg_stride = 5; cfg_kernel = 0;
    @(negedge clk); cfg_wr = 0; tick = 1; pc = 16'h2020; pc_kernel = 1;
    idle(3);

    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      int r = (i * 7919 + 13) % 97;
      if (r < 8) cfg(AW'((i * 331) & 'h7FFC), AW'(((i * 331) & 'h7FFC) + 'h900), SW'(r == 7 ? 0 : (1 << r)), i[2]);
      else if (r < 12) idle(1);
      else samp(AW'((i * 2741) & 'h7FFF), i[3] ^ i[0]);
    end
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule